// File: doc/BRIEF.md
# Sub-frame Gain Multiplier and Stereo Output Latch

This block sits behind a biphase-mark line decoder. It takes the recovered bit stream one bit strobe at a time and counts slot positions within a 64-slot stereo frame. From each 32-slot sub-frame it captures 16 audio bits and the validity flag. At the last slot of the sub-frame it multiplies the audio word by a 5-bit unsigned gain and loads the 21-bit product into the left or the right output register.

Frame alignment comes from a separate frame-start pulse, which sets the slot count to zero. After that pulse the counter runs freely and wraps once per frame. The first sub-frame of a frame feeds the left output and the second feeds the right. A sub-frame whose validity flag is 1 leaves its output register unchanged. Preamble, auxiliary, the four lowest audio bits, user, channel-status and parity slots are received and discarded.

Top module: `pcm_gain_latch`

## Requirements
- R1: After reset both `left_pcm` and `right_pcm` are zero.
- R2: A `frame_sof` pulse sets the slot count to 0, so the next accepted strobe is slot 0. A `bit_stb` in the same cycle as `frame_sof` is discarded.
- R3: Within a sub-frame (slots 0..31), slots 12..27 carry the 16 audio bits least significant first, with slot 12 being bit 0. Slot 28 carries the validity flag.
- R4: The left register loads on the strobe of frame slot 31, and the right register loads on the strobe of frame slot 63. The new value is visible in the cycle after that strobe.
- R5: The loaded value is the unsigned product audio × gain, 21 bits wide, with no saturation (for example 0xFFFF × 31 = 2031585).
- R6: When the validity flag of a sub-frame is 1, its output register keeps its previous value.
- R7: Slots 0..11 and 29..31 have no effect on either output. These are the preamble, auxiliary data, the four low audio bits, user, channel status and parity.
- R8: The gain used is the value present on `gain` at the load strobe; gain values earlier in the sub-frame do not matter.
- R9: Without a new `frame_sof`, the slot count wraps from 63 to 0 and the following frame loads left then right again.
- R10: Outputs change only at a load point; between load points they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe: a decoded bit is present on `bit_val` |
| bit_val | input | 1 | Decoded bit value |
| frame_sof | input | 1 | Frame-start pulse from the preamble detector |
| gain | input | 5 | Unsigned gain, sampled at the load strobe |
| left_pcm | output | 21 | Left channel scaled sample |
| right_pcm | output | 21 | Right channel scaled sample |

## Verification
The bench builds the block with its default parameters: 16 audio bits, 5 gain bits and 32 slots per sub-frame. These values bring the full-scale product 0xFFFF × 31 and the zero-gain case within reach, along with the 63-to-0 wrap of the 6-bit slot count. They also let the bench reach the single-bit edges of the audio field (slots 12 and 27) against the discarded low audio slots 8..11. Frame starts are sent both on their own and together with a strobe, after misaligned lead-in bits. Validity-1 sub-frames are placed next to valid ones so that the held values are distinct from the values that would have loaded.

// File: rtl/pcm_gain_pkg.sv
package pcm_gain_pkg;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/pcm_slot_ctr.sv
module pcm_slot_ctr
    import pcm_gain_pkg::*;
#(
    parameter int SUB_SLOTS = 32,
    localparam int CNT_W = $clog2(2 * SUB_SLOTS),
    localparam int SUB_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             sof,
    output logic [CNT_W-1:0] slot,
    output logic [SUB_W-1:0] sub_slot,
    output logic             load_en,
    output chan_e            load_ch
);
    typedef struct packed {
        logic [CNT_W-1:0] slot;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (sof) begin
            ctr_d.slot = '0;
        end else if (stb) begin
            ctr_d.slot = ctr_q.slot + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign slot     = ctr_q.slot;
    assign sub_slot = ctr_q.slot[SUB_W-1:0];
    assign load_en  = stb && !sof && (int'(ctr_q.slot[SUB_W-1:0]) == SUB_SLOTS - 1);
    assign load_ch  = chan_e'(ctr_q.slot[CNT_W-1]);
endmodule

// File: rtl/pcm_field_cap.sv
module pcm_field_cap #(
    parameter int AUDIO_W        = 16,
    parameter int AUDIO_LSB_SLOT = 12,
    parameter int VALID_SLOT     = 28,
    parameter int SUB_W          = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb,
    input  logic               sof,
    input  logic               bit_in,
    input  logic [SUB_W-1:0]   sub_slot,
    output logic [AUDIO_W-1:0] audio,
    output logic               inval
);
    typedef struct packed {
        logic [AUDIO_W-1:0] audio;
        logic               inval;
    } cap_t;

    cap_t cap_d, cap_q;
    logic take;

    assign take = stb && !sof;

    always_comb begin
        cap_d = cap_q;
        for (int i = 0; i < AUDIO_W; i++) begin
            if (take && int'(sub_slot) == AUDIO_LSB_SLOT + i) begin
                cap_d.audio[i] = bit_in;
            end
        end
        if (take && int'(sub_slot) == VALID_SLOT) begin
            cap_d.inval = bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.audio <= '0;
            cap_q.inval <= 1'b1;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign audio = cap_q.audio;
    assign inval = cap_q.inval;
endmodule

// File: rtl/pcm_gain_mult.sv
module pcm_gain_mult #(
    parameter int AUDIO_W = 16,
    parameter int GAIN_W  = 5,
    localparam int OUT_W  = AUDIO_W + GAIN_W
) (
    input  logic [AUDIO_W-1:0] audio,
    input  logic [GAIN_W-1:0]  gain,
    output logic [OUT_W-1:0]   product
);
    logic [OUT_W-1:0] pp [GAIN_W];

    for (genvar g = 0; g < GAIN_W; g++) begin : g_pp
        assign pp[g] = gain[g] ? (OUT_W'(audio) << g) : '0;
    end

    always_comb begin
        product = '0;
        for (int i = 0; i < GAIN_W; i++) begin
            product = product + pp[i];
        end
    end
endmodule

// File: rtl/pcm_gain_latch.sv
module pcm_gain_latch
    import pcm_gain_pkg::*;
#(
    parameter int AUDIO_W        = 16,
    parameter int GAIN_W         = 5,
    parameter int SUB_SLOTS      = 32,
    parameter int AUDIO_LSB_SLOT = 12,
    parameter int VALID_SLOT     = 28,
    localparam int OUT_W = AUDIO_W + GAIN_W,
    localparam int CNT_W = $clog2(2 * SUB_SLOTS),
    localparam int SUB_W = CNT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              frame_sof,
    input  logic [GAIN_W-1:0] gain,
    output logic [OUT_W-1:0]  left_pcm,
    output logic [OUT_W-1:0]  right_pcm
);
    typedef struct packed {
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
    } outs_t;

    logic [CNT_W-1:0]   slot_q;
    logic [SUB_W-1:0]   sub_slot;
    logic               load_en;
    chan_e              load_ch;
    logic [AUDIO_W-1:0] audio_q;
    logic               inval_q;
    logic [OUT_W-1:0]   product;
    outs_t              outs_d, outs_q;

    pcm_slot_ctr #(.SUB_SLOTS(SUB_SLOTS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (bit_stb),
        .sof      (frame_sof),
        .slot     (slot_q),
        .sub_slot (sub_slot),
        .load_en  (load_en),
        .load_ch  (load_ch)
    );

    pcm_field_cap #(
        .AUDIO_W        (AUDIO_W),
        .AUDIO_LSB_SLOT (AUDIO_LSB_SLOT),
        .VALID_SLOT     (VALID_SLOT),
        .SUB_W          (SUB_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (bit_stb),
        .sof      (frame_sof),
        .bit_in   (bit_val),
        .sub_slot (sub_slot),
        .audio    (audio_q),
        .inval    (inval_q)
    );

    pcm_gain_mult #(.AUDIO_W(AUDIO_W), .GAIN_W(GAIN_W)) u_mult (
        .audio   (audio_q),
        .gain    (gain),
        .product (product)
    );

    always_comb begin
        outs_d = outs_q;
        if (load_en && !inval_q) begin
            if (load_ch == CH_LEFT) begin
                outs_d.left = product;
            end else begin
                outs_d.right = product;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outs_q <= '0;
        end else begin
            outs_q <= outs_d;
        end
    end

    assign left_pcm  = outs_q.left;
    assign right_pcm = outs_q.right;
endmodule

// File: rtl/pcm_gain_latch_chk.sv
module pcm_gain_latch_chk #(
    parameter int CNT_W = 6,
    parameter int OUT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_stb,
    input logic             frame_sof,
    input logic [CNT_W-1:0] slot_q,
    input logic             load_en,
    input logic             load_ch,
    input logic             inval_q,
    input logic [OUT_W-1:0] product,
    input logic [OUT_W-1:0] left_pcm,
    input logic [OUT_W-1:0] right_pcm
);
    p_sof_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sof |=> slot_q == '0);

    p_slot_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !frame_sof) |=> slot_q == CNT_W'($past(slot_q) + CNT_W'(1)));

    p_left_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && !load_ch) |=> $stable(left_pcm));

    p_right_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && load_ch) |=> $stable(right_pcm));

    p_invalid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && inval_q) |=> ($stable(left_pcm) && $stable(right_pcm)));

    p_left_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !load_ch && !inval_q) |=> left_pcm == $past(product));

    p_right_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_ch && !inval_q) |=> right_pcm == $past(product));
endmodule

bind pcm_gain_latch pcm_gain_latch_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .frame_sof (frame_sof),
    .slot_q    (slot_q),
    .load_en   (load_en),
    .load_ch   (load_ch),
    .inval_q   (inval_q),
    .product   (product),
    .left_pcm  (left_pcm),
    .right_pcm (right_pcm)
);

// File: tb/pcm_gain_latch_test.sv
`timescale 1ns/1ps
module pcm_gain_latch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic        bit_val = 1'b0;
    logic        frame_sof = 1'b0;
    logic [4:0]  gain = '0;
    logic [20:0] left_pcm, right_pcm;

    int checks = 0;
    int errors = 0;
    logic [20:0] exp_l = '0;
    logic [20:0] exp_r = '0;
    bit done = 1'b0;

    typedef struct {
        logic [20:0] l;
        logic [20:0] r;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    pcm_gain_latch uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .frame_sof (frame_sof),
        .gain      (gain),
        .left_pcm  (left_pcm),
        .right_pcm (right_pcm)
    );

    task automatic check_out(input logic [20:0] el, input logic [20:0] er, input string tag);
        checks++;
        if (left_pcm !== el || right_pcm !== er) begin
            errors++;
            $display("FAIL %s: left=%0d right=%0d expected left=%0d right=%0d",
                     tag, left_pcm, right_pcm, el, er);
        end
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check_out(it.l, it.r, it.tag);
            end
        end
    end

    task automatic send_bit(input logic b, input logic [4:0] g);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = b;
        gain    = g;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk);
        frame_sof = 1'b1;
        @(negedge clk);
        frame_sof = 1'b0;
    endtask

    task automatic sof_with_strobe();
        @(negedge clk);
        frame_sof = 1'b1;
        bit_stb   = 1'b1;
        bit_val   = 1'b1;
        @(negedge clk);
        frame_sof = 1'b0;
        bit_stb   = 1'b0;
    endtask

    // driver: one sub-frame; pushes the expected outputs after its load strobe
    task automatic send_sub(input bit right, input logic [15:0] a, input logic [3:0] lo,
                            input logic v, input logic [3:0] pre, input logic [3:0] aux,
                            input logic [2:0] ucp, input logic [4:0] g_early,
                            input logic [4:0] g_load, input string tag);
        item_t it;
        for (int s = 0; s < 32; s++) begin
            logic b;
            if (s < 4)       b = pre[s];
            else if (s < 8)  b = aux[s-4];
            else if (s < 12) b = lo[s-8];
            else if (s < 28) b = a[s-12];
            else if (s == 28) b = v;
            else             b = ucp[s-29];
            if (s == 20) check_out(exp_l, exp_r, "R10 hold mid sub-frame");
            send_bit(b, (s == 31) ? g_load : g_early);
        end
        if (!v) begin
            if (right) exp_r = 21'(a) * 21'(g_load);
            else       exp_l = 21'(a) * 21'(g_load);
        end
        it.l = exp_l;
        it.r = exp_r;
        it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out('0, '0, "R1 reset value");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_out('0, '0, "R1 after reset release");

        // misaligned lead-in, then a frame start
        for (int i = 0; i < 10; i++) send_bit(i[0], 5'd9);
        check_out('0, '0, "R1 no load before alignment");
        pulse_sof();
        send_sub(0, 16'd1234, 4'h0, 1'b0, 4'hA, 4'h3, 3'b101, 5'd3, 5'd3, "R4 left load 1234x3");
        send_sub(1, 16'hFFFF, 4'h0, 1'b0, 4'h5, 4'h0, 3'b000, 5'd31, 5'd31, "R5 right full scale");

        // wrap without a new frame start; left invalid, right gain zero
        send_sub(0, 16'h5555, 4'h0, 1'b1, 4'h0, 4'h0, 3'b000, 5'd7, 5'd7, "R6 left invalid holds");
        send_sub(1, 16'h00FF, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd0, 5'd0, "R9 wrap right gain 0");

        // junk in ignored slots, both polarities
        send_sub(0, 16'h0101, 4'hF, 1'b0, 4'hF, 4'hF, 3'b111, 5'd7, 5'd7, "R7 ones in ignored slots");
        send_sub(1, 16'h0101, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd7, 5'd7, "R7 zeros in ignored slots");

        // gain changes before the load point do not count
        send_sub(0, 16'd1000, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd31, 5'd2, "R8 gain at load only");
        send_sub(1, 16'd999, 4'h0, 1'b1, 4'h0, 4'h0, 3'b000, 5'd1, 5'd1, "R6 right invalid holds");

        // bit-order edges of the audio field
        send_sub(0, 16'h8001, 4'hF, 1'b0, 4'h0, 4'h0, 3'b000, 5'd1, 5'd1, "R3 lsb first 0x8001");
        send_sub(1, 16'h0002, 4'hE, 1'b0, 4'h0, 4'h0, 3'b000, 5'd16, 5'd16, "R3 bit1 x16");

        // realignment: frame start together with a strobe discards that strobe
        for (int i = 0; i < 7; i++) send_bit(1'b1, 5'd5);
        sof_with_strobe();
        send_sub(0, 16'd300, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd4, 5'd4, "R2 sof with strobe left");
        send_sub(1, 16'd77, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd9, 5'd9, "R2 sof with strobe right");

        // mid-frame realignment with a lone frame start
        for (int i = 0; i < 20; i++) send_bit(1'b0, 5'd5);
        pulse_sof();
        send_sub(0, 16'hABCD, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd17, 5'd17, "R2 lone sof left");
        send_sub(1, 16'h1234, 4'h0, 1'b0, 4'h0, 4'h0, 3'b000, 5'd30, 5'd30, "R4 right after realign");

        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule